// File: doc/BRIEF.md
# Programmable LCD Sync Timing Generator

This block drives the timing side of a parallel RGB panel. From a system clock it derives a pixel strobe, then walks a horizontal counter and a vertical counter through four phases per axis: sync pulse, back porch, active region, front porch. The counters are decoded into HSYNC, VSYNC and a data-enable, and the position inside the active region is exported as a pixel index and a line index for the pixel fetch logic that sits downstream.

All geometry is supplied as static inputs taken from configuration registers. Most lengths are written as the length minus one; the vertical back porch is written as the raw line count, so zero is a legal value. The divider field holds the division ratio minus two, and a bypass select lets the system clock serve as the pixel clock. Each sync output has its own active-low select.

Top module: `lcd_timing_gen`

## Requirements
- R1: While rst_ni is low, den_o is low and pix_x_o and pix_y_o are zero; the counters restart at the first pixel of the sync phase, so hsync_o and vsync_o show their active level.
- R2: With div_bypass_i low, pix_stb_o is high for exactly one system clock in every div_sel_i+2 clocks, the first one div_sel_i+1 clocks after reset release.
- R3: With div_bypass_i high, pix_stb_o is high on every system clock.
- R4: Each line consists, in this order, of hs_width_m1_i+1 sync pixels, hbp_m1_i+1 back-porch pixels, the active pixels and hfp_m1_i+1 front-porch pixels; a pixel lasts one strobe.
- R5: Each frame consists, in this order, of vs_width_m1_i+1 sync lines, vbp_lines_i back-porch lines (zero allowed), the active lines and vfp_m1_i+1 front-porch lines; the line counter advances only when a line ends.
- R6: With hs_low_i (vs_low_i) at 0 the sync output is 1 during its sync phase and 0 elsewhere; at 1 the levels are inverted.
- R7: den_o is high exactly when both the horizontal and the vertical position are inside the active region.
- R8: pix_x_o and pix_y_o give the zero-based pixel and line index inside the active region and are zero outside it.
- R9: The active width is min(h_act_m1_i+1, 1024) and the active height is min(v_act_m1_i+1, 768).
- R10: Horizontal position, and with it every output other than pix_stb_o, changes only on the clock edge following a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_sel_i | input | 8 | Division ratio minus two |
| div_bypass_i | input | 1 | Use system clock as pixel clock |
| hs_width_m1_i | input | 11 | HSYNC width minus one |
| hbp_m1_i | input | 11 | Horizontal back porch minus one |
| h_act_m1_i | input | 11 | Active pixels per line minus one |
| hfp_m1_i | input | 11 | Horizontal front porch minus one |
| vs_width_m1_i | input | 11 | VSYNC width in lines minus one |
| vbp_lines_i | input | 11 | Vertical back porch in lines, raw |
| v_act_m1_i | input | 11 | Active lines per frame minus one |
| vfp_m1_i | input | 11 | Vertical front porch minus one |
| hs_low_i | input | 1 | HSYNC active low when set |
| vs_low_i | input | 1 | VSYNC active low when set |
| pix_stb_o | output | 1 | One-clock pixel strobe |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| den_o | output | 1 | Data enable |
| pix_x_o | output | 10 | Pixel index in active line |
| pix_y_o | output | 10 | Line index in active frame |

## Verification
The embedded properties take the divider and geometry inputs as quasi-static: they hold while the block runs and change only with reset asserted, so the position counters never sit beyond a freshly shortened line or frame. The bench follows that rule by reprogramming every scenario under reset, covering ratio two and five, bypass, both sync polarities, a zero vertical back porch and oversized active fields that must be clipped.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int unsigned TG_FIELD_W = 11;
  localparam int unsigned TG_DIV_W   = 8;
  localparam int unsigned TG_MAX_W   = 1024;
  localparam int unsigned TG_MAX_H   = 768;

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_BP   = 2'd1,
    PH_ACT  = 2'd2,
    PH_FP   = 2'd3
  } tg_phase_e;
endpackage

// File: rtl/lcd_tg_div.sv
module lcd_tg_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_sel_i,
  input  logic             bypass_i,
  output logic             stb_o
);
  localparam int unsigned CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;

  assign term  = {1'b0, div_sel_i} + CNT_W'(1);
  assign stb_o = bypass_i || (cnt_q >= term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (stb_o) cnt_q <= '0;
    else            cnt_q <= cnt_q + CNT_W'(1);
  end

  // divided strobe is never two cycles wide (ratio >= 2)
  assert_stb_gap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass_i && $stable(bypass_i) && stb_o) |=> (!stb_o || bypass_i));
endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis
  import lcd_tg_pkg::*;
#(
  parameter int unsigned FIELD_W = 11,
  parameter int unsigned MAX_ACT = 1024,
  parameter bit          RAW_BP  = 1'b0,
  localparam int unsigned POS_W  = FIELD_W + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic [FIELD_W-1:0] sync_m1_i,
  input  logic [FIELD_W-1:0] bp_i,
  input  logic [FIELD_W-1:0] act_m1_i,
  input  logic [FIELD_W-1:0] fp_m1_i,
  output logic               wrap_o,
  output logic               sync_o,
  output logic               act_o,
  output logic [POS_W-1:0]   idx_o
);
  localparam logic [POS_W-1:0] ACT_CAP = POS_W'(MAX_ACT);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] sync_len, bp_len, act_full, act_len, fp_len;
  logic [POS_W-1:0] act_start, act_end, last_pos;
  tg_phase_e        phase;

  assign sync_len = POS_W'(sync_m1_i) + POS_W'(1);
  assign fp_len   = POS_W'(fp_m1_i) + POS_W'(1);
  assign act_full = POS_W'(act_m1_i) + POS_W'(1);
  assign act_len  = (act_full > ACT_CAP) ? ACT_CAP : act_full;

  generate
    if (RAW_BP) begin : g_bp_raw
      assign bp_len = POS_W'(bp_i);
    end else begin : g_bp_m1
      assign bp_len = POS_W'(bp_i) + POS_W'(1);
    end
  endgenerate

  assign act_start = sync_len + bp_len;
  assign act_end   = act_start + act_len;
  assign last_pos  = act_end + fp_len - POS_W'(1);

  always_comb begin
    if (pos_q < sync_len)       phase = PH_SYNC;
    else if (pos_q < act_start) phase = PH_BP;
    else if (pos_q < act_end)   phase = PH_ACT;
    else                        phase = PH_FP;
  end

  assign wrap_o = step_i && (pos_q >= last_pos);
  assign sync_o = (phase == PH_SYNC);
  assign act_o  = (phase == PH_ACT);
  assign idx_o  = act_o ? (pos_q - act_start) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= '0;
    else if (wrap_o)  pos_q <= '0;
    else if (step_i)  pos_q <= pos_q + POS_W'(1);
  end

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pos_q));
  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (pos_q == '0 && sync_o));
  assert_act_cap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |-> (idx_o < ACT_CAP));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int unsigned FIELD_W = TG_FIELD_W,
  parameter int unsigned DIV_W   = TG_DIV_W,
  parameter int unsigned MAX_W   = TG_MAX_W,
  parameter int unsigned MAX_H   = TG_MAX_H,
  localparam int unsigned XW     = $clog2(MAX_W),
  localparam int unsigned YW     = $clog2(MAX_H)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [DIV_W-1:0]   div_sel_i,
  input  logic               div_bypass_i,
  input  logic [FIELD_W-1:0] hs_width_m1_i,
  input  logic [FIELD_W-1:0] hbp_m1_i,
  input  logic [FIELD_W-1:0] h_act_m1_i,
  input  logic [FIELD_W-1:0] hfp_m1_i,
  input  logic [FIELD_W-1:0] vs_width_m1_i,
  input  logic [FIELD_W-1:0] vbp_lines_i,
  input  logic [FIELD_W-1:0] v_act_m1_i,
  input  logic [FIELD_W-1:0] vfp_m1_i,
  input  logic               hs_low_i,
  input  logic               vs_low_i,
  output logic               pix_stb_o,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               den_o,
  output logic [XW-1:0]      pix_x_o,
  output logic [YW-1:0]      pix_y_o
);
  localparam int unsigned POS_W = FIELD_W + 3;

  logic             stb, h_wrap, v_wrap;
  logic             h_sync, h_act, v_sync, v_act;
  logic [POS_W-1:0] h_idx, v_idx;

  lcd_tg_div #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .div_sel_i(div_sel_i),
    .bypass_i (div_bypass_i),
    .stb_o    (stb)
  );

  lcd_tg_axis #(.FIELD_W(FIELD_W), .MAX_ACT(MAX_W), .RAW_BP(1'b0)) u_h (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (stb),
    .sync_m1_i(hs_width_m1_i),
    .bp_i     (hbp_m1_i),
    .act_m1_i (h_act_m1_i),
    .fp_m1_i  (hfp_m1_i),
    .wrap_o   (h_wrap),
    .sync_o   (h_sync),
    .act_o    (h_act),
    .idx_o    (h_idx)
  );

  lcd_tg_axis #(.FIELD_W(FIELD_W), .MAX_ACT(MAX_H), .RAW_BP(1'b1)) u_v (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (h_wrap),
    .sync_m1_i(vs_width_m1_i),
    .bp_i     (vbp_lines_i),
    .act_m1_i (v_act_m1_i),
    .fp_m1_i  (vfp_m1_i),
    .wrap_o   (v_wrap),
    .sync_o   (v_sync),
    .act_o    (v_act),
    .idx_o    (v_idx)
  );

  assign pix_stb_o = stb;
  assign hsync_o   = h_sync ^ hs_low_i;
  assign vsync_o   = v_sync ^ vs_low_i;
  assign den_o     = h_act && v_act;
  assign pix_x_o   = den_o ? h_idx[XW-1:0] : '0;
  assign pix_y_o   = den_o ? v_idx[YW-1:0] : '0;

  // frame wrap lands on the first sync line
  assert_frame_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_wrap |=> (vsync_o != vs_low_i));
  // vertical state moves only at a line end
  assert_vsync_steady_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !h_wrap |=> $stable(vsync_o) || !$stable(vs_low_i));
  assert_den_stb_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb && $stable(div_bypass_i) |=> $stable(den_o) && $stable(pix_x_o));
endmodule

// File: tb/lcd_timing_gen_tb.sv
module lcd_timing_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int c_div, c_byp, h_s, h_b, h_a, h_f, v_s, v_b, v_a, v_f, c_hlow, c_vlow;
  int m_dc, m_hp, m_vp;
  int checks = 0, errors = 0, cycles = 0, max_x, max_y;
  bit done = 1'b0;
  string tag_over = "";

  logic       pix_stb_o, hsync_o, vsync_o, den_o;
  logic [9:0] pix_x_o, pix_y_o;

  lcd_timing_gen u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .div_sel_i    (8'(c_div)),
    .div_bypass_i (c_byp != 0),
    .hs_width_m1_i(11'(h_s)),
    .hbp_m1_i     (11'(h_b)),
    .h_act_m1_i   (11'(h_a)),
    .hfp_m1_i     (11'(h_f)),
    .vs_width_m1_i(11'(v_s)),
    .vbp_lines_i  (11'(v_b)),
    .v_act_m1_i   (11'(v_a)),
    .vfp_m1_i     (11'(v_f)),
    .hs_low_i     (c_hlow != 0),
    .vs_low_i     (c_vlow != 0),
    .pix_stb_o    (pix_stb_o),
    .hsync_o      (hsync_o),
    .vsync_o      (vsync_o),
    .den_o        (den_o),
    .pix_x_o      (pix_x_o),
    .pix_y_o      (pix_y_o)
  );

  function automatic int mn(int a, int b); return (a < b) ? a : b; endfunction
  function automatic int hsl(); return h_s + 1; endfunction
  function automatic int hst(); return h_s + 1 + h_b + 1; endfunction
  function automatic int hal(); return mn(h_a + 1, 1024); endfunction
  function automatic int htot(); return hst() + hal() + h_f + 1; endfunction
  function automatic int vst(); return v_s + 1 + v_b; endfunction
  function automatic int val(); return mn(v_a + 1, 768); endfunction
  function automatic int vtot(); return vst() + val() + v_f + 1; endfunction
  function automatic bit exp_stb(); return (c_byp != 0) || (m_dc == c_div + 1); endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  task automatic tick();
    bit hact, vact, hs, vs;
    string tx;
    if (!rst_ni) begin
      m_dc = 0; m_hp = 0; m_vp = 0;
    end else if (exp_stb()) begin
      m_dc = 0;
      if (m_hp >= htot() - 1) begin
        m_hp = 0;
        m_vp = (m_vp >= vtot() - 1) ? 0 : m_vp + 1;
      end else m_hp++;
    end else m_dc++;
    @(negedge clk_i);
    cycles++;
    hs   = m_hp < hsl();
    vs   = m_vp < v_s + 1;
    hact = (m_hp >= hst()) && (m_hp < hst() + hal());
    vact = (m_vp >= vst()) && (m_vp < vst() + val());
    if (!rst_ni) begin
      chk("R1", "den", den_o, 0);
      chk("R1", "x", pix_x_o, 0);
      chk("R1", "y", pix_y_o, 0);
      chk("R1", "hsync", hsync_o, 1 ^ c_hlow);
      chk("R1", "vsync", vsync_o, 1 ^ c_vlow);
    end else begin
      chk(tag_over != "" ? tag_over : (c_byp != 0 ? "R3" : "R2"), "stb", pix_stb_o, exp_stb());
      chk(c_hlow != 0 ? "R6" : "R4", "hsync", hsync_o, hs ^ c_hlow[0]);
      chk(c_vlow != 0 ? "R6" : "R5", "vsync", vsync_o, vs ^ c_vlow[0]);
      chk("R7", "den", den_o, hact && vact);
      tx = (tag_over != "") ? tag_over : "R8";
      chk(tx, "x", pix_x_o, (hact && vact) ? m_hp - hst() : 0);
      chk(tx, "y", pix_y_o, (hact && vact) ? m_vp - vst() : 0);
      if (den_o && pix_x_o > max_x) max_x = pix_x_o;
      if (den_o && pix_y_o > max_y) max_y = pix_y_o;
    end
  endtask

  task automatic scen(int dv, int by, int hs_, int hb, int ha, int hf,
                      int vs_, int vb, int va, int vf, int hl, int vl, int n);
    rst_ni = 1'b0;
    c_div = dv; c_byp = by; h_s = hs_; h_b = hb; h_a = ha; h_f = hf;
    v_s = vs_; v_b = vb; v_a = va; v_f = vf; c_hlow = hl; c_vlow = vl;
    max_x = 0; max_y = 0;
    repeat (3) tick();
    rst_ni = 1'b1;
    repeat (n) tick();
  endtask

  initial begin
    scen(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R2 ratio 2, R4/R5 small geometry, zero vertical back porch
    scen(0, 0, 1, 1, 3, 0, 0, 0, 2, 1, 0, 0, 440);
    // R3 bypass, R6 active-low syncs, nonzero raw back porch
    scen(0, 1, 1, 1, 3, 0, 0, 2, 2, 1, 1, 1, 240);
    // R10 ratio 5: outputs hold between strobes
    tag_over = "R10";
    scen(3, 0, 1, 1, 3, 0, 0, 0, 2, 1, 0, 1, 560);
    tag_over = "";
    // R9 width capped at 1024
    scen(0, 1, 1, 1, 1100, 0, 0, 0, 2, 1, 0, 0, 6400);
    chk("R9", "max_x", max_x, 1023);
    // R9 height capped at 768
    scen(0, 1, 1, 1, 3, 0, 0, 1, 800, 1, 0, 0, 7000);
    chk("R9", "max_y", max_y, 767);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule